// File: doc/BRIEF.md
# SHA-1 Message Schedule Generator

This block turns one 512-bit message block into the eighty 32-bit schedule words that a SHA-1 compression engine consumes, one word per step. It does not store all eighty words. A sliding history of the sixteen most recent words is kept. Each time the consumer takes a word, the next word in the history is derived from four older entries: they are XORed together and the result is rotated left by one bit.

A new block is captured on any cycle in which `load_valid` is high, and the block is always accepted. The cycle after the load, the output stream starts at step 0. Words leave through a valid/ready pair. A word is consumed on a cycle where `word_valid` and `word_ready` are both high. If the consumer holds `word_ready` low, the current word and its step index stay unchanged for as long as needed, so back-pressure costs nothing. After step 79 has been consumed, `word_valid` falls and the generator stays idle until the next load. A load that arrives during a stream abandons that stream and takes priority over a transfer in the same cycle.

`word_step` and `word_last` go out alongside each word, so the round engine can pick its step constant and its logic function without a counter of its own.

Top module: `sha1_wsched`

## Requirements
- R1: After reset `word_valid` and `word_last` are low.
- R2: In the cycle after `load_valid` is sampled high, `word_valid` is high, `word_step` is 0 and `word_data` equals bits [511:480] of the loaded block.
- R3: For steps 0 to 15, `word_data` at step i equals block bits [511-32i : 480-32i], so the word order is big-endian.
- R4: For steps 16 to 79, the word at step t equals rotl1(W[t-3] ^ W[t-8] ^ W[t-14] ^ W[t-16]), where rotl1 moves bit 31 into bit 0.
- R5: Exactly 80 words are offered per block. `word_last` is high only while step 79 is offered. When step 79 is consumed, `word_valid` falls in the next cycle.
- R6: While `word_valid` is high and `word_ready` is low, `word_data` and `word_step` hold their values.
- R7: While `word_valid` is low, raising `word_ready` leaves `word_data` and `word_valid` unchanged.
- R8: A load during a stream restarts the output at step 0 of the new block, even if a transfer happens in the same cycle.
- R9: Each transfer below step 79 increments `word_step` by one in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Capture `load_block` and restart at step 0 |
| load_block | input | 512 | Message block; word 0 in the top 32 bits |
| word_ready | input | 1 | Consumer takes the offered word |
| word_valid | output | 1 | A schedule word is offered |
| word_data | output | 32 | Schedule word for the current step |
| word_step | output | 7 | Index of the current step, 0 to 79 |
| word_last | output | 1 | The offered word is step 79 |

## Verification
The following handshake properties are checked on every cycle by the assertions: the start at step 0 with the top word after a load, the hold under back-pressure, the step increment, the drop of `word_valid` after the last transfer, and the quiet idle state. The assertions cannot check the values of the eighty words. Only the bench's sweeps can show those: several block patterns are streamed under several ready patterns and each word is compared with a schedule computed in the bench. The restart during a stream is also covered by a bench scenario.

// File: rtl/sha1ws_pkg.sv
package sha1ws_pkg;
  // Distances back from the new word to its four source words
  localparam int unsigned TAP_D0 = 3;
  localparam int unsigned TAP_D1 = 8;
  localparam int unsigned TAP_D2 = 14;

  function automatic logic [31:0] rotl1_32(input logic [31:0] x);
    return {x[30:0], x[31]};
  endfunction
endpackage

// File: rtl/ws_expand.sv
module ws_expand #(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] w_d3,
  input  logic [WORD_W-1:0] w_d8,
  input  logic [WORD_W-1:0] w_d14,
  input  logic [WORD_W-1:0] w_d16,
  output logic [WORD_W-1:0] w_new
);
  logic [WORD_W-1:0] mix;

  always_comb begin
    mix   = w_d3 ^ w_d8 ^ w_d14 ^ w_d16;
    w_new = {mix[WORD_W-2:0], mix[WORD_W-1]};
  end
endmodule

// File: rtl/ws_window.sv
module ws_window #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DIST0  = 3,
  parameter int unsigned DIST1  = 8,
  parameter int unsigned DIST2  = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [WORD_W*DEPTH-1:0] load_words,
  input  logic                    shift,
  input  logic [WORD_W-1:0]       shift_in,
  output logic [WORD_W-1:0]       head,
  output logic [WORD_W-1:0]       tap0,
  output logic [WORD_W-1:0]       tap1,
  output logic [WORD_W-1:0]       tap2
);
  localparam int unsigned BLK_W = WORD_W * DEPTH;
  localparam int unsigned IDX0  = DEPTH - DIST0;
  localparam int unsigned IDX1  = DEPTH - DIST1;
  localparam int unsigned IDX2  = DEPTH - DIST2;

  // slot k holds the word for step (current + k)
  logic [WORD_W-1:0] slot [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic [WORD_W-1:0] nxt;
    if (k == DEPTH - 1) begin : g_top
      assign nxt = shift_in;
    end else begin : g_mid
      assign nxt = slot[k+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[k] <= '0;
      end else if (load) begin
        slot[k] <= load_words[BLK_W-1-k*WORD_W -: WORD_W];
      end else if (shift) begin
        slot[k] <= nxt;
      end
    end
  end

  assign head = slot[0];
  assign tap0 = slot[IDX0];
  assign tap1 = slot[IDX1];
  assign tap2 = slot[IDX2];
endmodule

// File: rtl/ws_step_ctr.sv
module ws_step_ctr #(
  parameter int unsigned NUM_STEPS = 80,
  parameter int unsigned STEP_W    = $clog2(NUM_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  output logic [STEP_W-1:0] step,
  output logic              active,
  output logic              final_step
);
  localparam logic [STEP_W-1:0] DONE = STEP_W'(NUM_STEPS);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_STEPS - 1);

  logic [STEP_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= DONE;
    end else if (restart) begin
      cnt <= '0;
    end else if (advance && cnt != DONE) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign step       = cnt;
  assign active     = (cnt < DONE);
  assign final_step = (cnt == LAST);
endmodule

// File: rtl/sha1_wsched.sv
module sha1_wsched #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned WIN_DEPTH = 16,
  parameter int unsigned NUM_STEPS = 80,
  localparam int unsigned BLK_W    = WORD_W * WIN_DEPTH,
  localparam int unsigned STEP_W   = $clog2(NUM_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [BLK_W-1:0]  load_block,
  input  logic              word_ready,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic [STEP_W-1:0] word_step,
  output logic              word_last
);
  import sha1ws_pkg::*;

  logic              xfer;
  logic              active;
  logic              fin;
  logic [WORD_W-1:0] head, t0, t1, t2, fresh;

  assign xfer = active & word_ready;

  ws_step_ctr #(.NUM_STEPS(NUM_STEPS), .STEP_W(STEP_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (load_valid),
    .advance    (xfer),
    .step       (word_step),
    .active     (active),
    .final_step (fin)
  );

  ws_window #(
    .WORD_W (WORD_W),
    .DEPTH  (WIN_DEPTH),
    .DIST0  (TAP_D0),
    .DIST1  (TAP_D1),
    .DIST2  (TAP_D2)
  ) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_valid),
    .load_words (load_block),
    .shift      (xfer),
    .shift_in   (fresh),
    .head       (head),
    .tap0       (t0),
    .tap1       (t1),
    .tap2       (t2)
  );

  ws_expand #(.WORD_W(WORD_W)) u_exp (
    .w_d3  (t0),
    .w_d8  (t1),
    .w_d14 (t2),
    .w_d16 (head),
    .w_new (fresh)
  );

  assign word_valid = active;
  assign word_data  = head;
  assign word_last  = fin;
endmodule

// File: rtl/sha1_wsched_chk.sv
module sha1_wsched_chk #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_STEPS = 80,
  parameter int unsigned STEP_W    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_valid,
  input logic [WORD_W-1:0] load_top,
  input logic              word_ready,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_data,
  input logic [STEP_W-1:0] word_step,
  input logic              word_last
);
  a_r1_idle_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!word_valid && !word_last));

  a_r2_load_starts_step0: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> (word_valid && word_step == '0 && word_data == $past(load_top)));

  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready && !load_valid) |=>
      (word_valid && $stable(word_data) && $stable(word_step)));

  a_r9_step_increments: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready && !load_valid && !word_last) |=>
      (word_valid && word_step == $past(word_step) + 1'b1));

  a_r5_stops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready && !load_valid && word_last) |=> !word_valid);

  a_r5_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (word_step < STEP_W'(NUM_STEPS)));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_valid && !load_valid) |=> (!word_valid && $stable(word_data)));
endmodule

bind sha1_wsched sha1_wsched_chk #(
  .WORD_W    (WORD_W),
  .NUM_STEPS (NUM_STEPS),
  .STEP_W    (STEP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_valid (load_valid),
  .load_top   (load_block[BLK_W-1 -: WORD_W]),
  .word_ready (word_ready),
  .word_valid (word_valid),
  .word_data  (word_data),
  .word_step  (word_step),
  .word_last  (word_last)
);

// File: tb/sha1_wsched_test.sv
module sha1_wsched_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_valid = 1'b0;
  logic [511:0] load_block = '0;
  logic         word_ready = 1'b0;
  logic         word_valid;
  logic [31:0]  word_data;
  logic [6:0]   word_step;
  logic         word_last;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_w [80];

  always #10 clk = ~clk;

  sha1_wsched uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (load_valid),
    .load_block (load_block),
    .word_ready (word_ready),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_step  (word_step),
    .word_last  (word_last)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] rl1(input logic [31:0] x);
    return {x[30:0], x[31]};
  endfunction

  task automatic fill_ref(input logic [511:0] b);
    for (int i = 0; i < 16; i++) exp_w[i] = b[511-32*i -: 32];
    for (int t = 16; t < 80; t++)
      exp_w[t] = rl1(exp_w[t-3] ^ exp_w[t-8] ^ exp_w[t-14] ^ exp_w[t-16]);
  endtask

  function automatic logic [511:0] make_block(input int p);
    logic [511:0] b;
    b = '0;
    for (int i = 0; i < 16; i++) begin
      case (p)
        0: b[511-32*i -: 32] = 32'h0;
        1: b[511-32*i -: 32] = 32'hffffffff;
        2: b[511-32*i -: 32] = (i == 15) ? 32'h1 : 32'h0;
        3: b[511-32*i -: 32] = 32'(i);
        4: b[511-32*i -: 32] = 32'h9e3779b9 * 32'(i + 1) ^ 32'h5bd1e995;
        default: b[511-32*i -: 32] = (i % 2 == 0) ? 32'ha5a5a5a5 : 32'h80000000;
      endcase
    end
    return b;
  endfunction

  function automatic bit ready_pat(input int mode, input int c);
    case (mode)
      0: return 1'b1;
      1: return (c % 2) == 1;
      2: return (c % 3) != 0;
      default: return (c % 7) < 2;
    endcase
  endfunction

  task automatic do_load(input logic [511:0] blk, input bit rdy);
    @(negedge clk);
    load_valid = 1'b1;
    load_block = blk;
    word_ready = rdy;
    @(negedge clk);
    load_valid = 1'b0;
    word_ready = 1'b0;
  endtask

  task automatic stream(input int mode);
    int  idx = 0;
    int  c = 0;
    bit  prev_stall = 1'b0;
    logic [31:0] hold;
    while (idx < 80) begin
      bit rdy;
      rdy = ready_pat(mode, c);
      c++;
      chk(word_valid, "R5 valid during stream", 32'(word_valid), 32'd1);
      chk(word_step == 7'(idx), "R9 step index", 32'(word_step), 32'(idx));
      if (prev_stall)
        chk(word_data == exp_w[idx], "R6 held word", word_data, exp_w[idx]);
      else if (idx < 16)
        chk(word_data == exp_w[idx], "R3 block word", word_data, exp_w[idx]);
      else
        chk(word_data == exp_w[idx], "R4 expanded word", word_data, exp_w[idx]);
      chk(word_last == (idx == 79), "R5 last flag", 32'(word_last), 32'(idx == 79));
      word_ready = rdy;
      prev_stall = !rdy;
      @(negedge clk);
      if (rdy) idx++;
    end
    word_ready = 1'b0;
    chk(!word_valid, "R5 valid drops after 80", 32'(word_valid), 32'd0);
    hold = word_data;
    word_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!word_valid, "R7 idle stays invalid", 32'(word_valid), 32'd0);
    chk(word_data == hold, "R7 idle word stable", word_data, hold);
    word_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!word_valid, "R1 valid after reset", 32'(word_valid), 32'd0);
    chk(!word_last, "R1 last after reset", 32'(word_last), 32'd0);

    for (int p = 0; p < 6; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [511:0] blk;
        blk = make_block(p);
        fill_ref(blk);
        do_load(blk, 1'b0);
        chk(word_valid && word_step == 7'd0, "R2 start at step 0", 32'(word_step), 32'd0);
        chk(word_data == blk[511:480], "R2 top word first", word_data, blk[511:480]);
        stream(m);
      end
    end

    // R8: reload in the middle of a stream, with a transfer in the same cycle
    begin
      logic [511:0] a, b;
      a = make_block(4);
      b = make_block(3);
      fill_ref(a);
      do_load(a, 1'b0);
      word_ready = 1'b1;
      repeat (30) @(negedge clk);
      chk(word_step == 7'd30, "R9 step after 30", 32'(word_step), 32'd30);
      chk(word_data == exp_w[30], "R4 word 30", word_data, exp_w[30]);
      fill_ref(b);
      do_load(b, 1'b1);
      chk(word_valid && word_step == 7'd0, "R8 restart step", 32'(word_step), 32'd0);
      chk(word_data == exp_w[0], "R8 restart word", word_data, exp_w[0]);
      stream(2);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule